// File: doc/BRIEF.md
# Open-Page DRAM Access Sequencer

This block drives one DRAM bank that has a row (page) buffer. Requests arrive over a valid/ready handshake. Each request carries a row part and a column part of the address, a read/write flag and write data. The sequencer turns each request into the bank commands it needs: precharge, row activate, and a column read or write strobe. It spaces these commands by cycle counts set as parameters, and for a read it returns the data with a one-cycle valid flag.

After an access the row is left open. A later request to the same row then needs only a column strobe. A request that finds the bank precharged needs an activate and a column strobe. A request to a different row than the open one needs a precharge first. A fixed recovery gap follows every column access, for the restore that a destructive read needs, so the minimum spacing between requests is longer than the access latency.

A free-running interval counter raises a refresh demand. The sequencer serves that demand as soon as the current access ends, before any waiting request. It closes an open row first, then activates the next row in sequence to refresh it. Requests are served strictly in the order they are accepted.

Top module: `dram_page_seq`

## Requirements
- R1: After reset no command or response pulse is asserted, `req_ready` is high, and the bank is treated as precharged with no row open.
- R2: `cmd_row` carries the request's row with `cmd_act`, and `cmd_col` carries the request's column with `cmd_rd` or `cmd_wr`.
- R3: A read to a precharged bank issues activate then column read, and `rsp_valid` rises exactly T_RCD+T_CL cycles after the handshake edge.
- R4: A read to the open row issues only a column read, and `rsp_valid` rises exactly T_CL cycles after the handshake edge.
- R5: A read to a row other than the open one issues precharge, activate and column read, with the response T_RP+T_RCD+T_CL cycles after the handshake edge.
- R6: At most one command is issued per cycle. An activate follows a precharge or refresh by at least T_RP or T_RCD cycles. A column strobe comes only on an open row, at least T_RCD cycles after its activate.
- R7: After each access `req_ready` stays low for T_REC cycles of recovery, so two accepted requests are at least latency+T_REC+1 cycles apart.
- R8: With the bank idle, `cmd_ref` pulses exactly every T_REFI cycles.
- R9: A refresh is only issued with no row open (an open row is precharged first). Its `cmd_row` counts up by one per refresh from 0 and wraps. After a refresh the next access takes the precharged-bank latency.
- R10: A pending refresh is served before a waiting request, so refreshes keep occurring under a continuous request stream.
- R11: A write stores `req_wdata` at its row and column and produces no response; a later read of that location returns it.
- R12: Read responses return in acceptance order, one per read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | ROW_W | Row part of the address |
| req_col | input | COL_W | Column part of the address |
| req_wdata | input | DATA_W | Write data |
| cmd_pre | output | 1 | Precharge pulse |
| cmd_act | output | 1 | Row activate pulse |
| cmd_rd | output | 1 | Column read pulse |
| cmd_wr | output | 1 | Column write pulse |
| cmd_ref | output | 1 | Refresh row-activate pulse |
| cmd_row | output | ROW_W | Row address for activate, precharge and refresh |
| cmd_col | output | COL_W | Column address for the column strobes |
| cmd_wdata | output | DATA_W | Write data with cmd_wr |
| dram_rdata | input | DATA_W | Read data from the bank, valid the cycle after cmd_rd |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_data | output | DATA_W | Read data |

## Verification
The bench walks the three latency classes on purpose: a first access to a cold bank, a repeat to the same row, and a jump to another row. A design that misjudged the open row would either skip a needed precharge, which the bench's bank model flags as an activate on an open bank, or waste cycles on a hit, which shows up as a wrong latency. A long idle stretch checks the refresh cadence. The first access after it checks that refresh left the row closed. A design that kept the old row marked open would report a hit latency there and strobe a closed bank. A back-to-back stream with writes mixed in checks ordering, recovery spacing and data written then read back. It also checks that refresh is not starved while requests keep waiting.

// File: rtl/dps_pkg.sv
package dps_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_ACT, S_COL, S_REC, S_RPRE, S_REF
    } seq_st_e;

    typedef enum logic [1:0] {
        K_HIT, K_CLOSED, K_CONFLICT
    } acc_kind_e;
endpackage

// File: rtl/dps_refresh_ctl.sv
module dps_refresh_ctl #(
    parameter int T_REFI = 120,
    parameter int ROW_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack,
    output logic             pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CW = (T_REFI > 1) ? $clog2(T_REFI) : 1;

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic             pend;
        logic [ROW_W-1:0] row;
    } rf_t;

    rf_t rf_d, rf_q;
    logic hit;

    always_comb begin
        rf_d = rf_q;
        hit  = (rf_q.cnt == CW'(T_REFI - 1));
        rf_d.cnt = hit ? '0 : rf_q.cnt + 1'b1;
        if (ack) begin
            rf_d.row = rf_q.row + 1'b1;
        end
        rf_d.pend = hit | (rf_q.pend & ~ack);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign pending = rf_q.pend;
    assign ref_row = rf_q.row;

    p_ack_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> pending);
    p_pending_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack) |=> pending);
    p_row_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (ref_row == $past(ref_row) + 1'b1));
endmodule

// File: rtl/dps_row_track.sv
module dps_row_track
    import dps_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_set,
    input  logic             close,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] probe_row,
    output acc_kind_e        kind,
    output logic             is_open,
    output logic [ROW_W-1:0] cur_row
);
    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } trk_t;

    trk_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (close) begin
            tk_d.open = 1'b0;
        end
        if (open_set) begin
            tk_d.open = 1'b1;
            tk_d.row  = set_row;
        end
        if (!tk_q.open) begin
            kind = K_CLOSED;
        end else if (tk_q.row == probe_row) begin
            kind = K_HIT;
        end else begin
            kind = K_CONFLICT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tk_q <= '0;
        end else begin
            tk_q <= tk_d;
        end
    end

    assign is_open = tk_q.open;
    assign cur_row = tk_q.row;

    p_open_row_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_open && !open_set && !close) |=> (is_open && $stable(cur_row)));
    p_no_set_and_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_set && close));
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
    import dps_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 3,
    parameter int T_CL   = 3,
    parameter int T_REC  = 2,
    parameter int T_REFI = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cmd_pre,
    output logic              cmd_act,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic              cmd_ref,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int MAX_A = (T_RP > T_RCD) ? T_RP : T_RCD;
    localparam int MAX_B = (T_CL > T_REC) ? T_CL : T_REC;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W = $clog2(MAX_T + 1);
    localparam int GAP_W = CNT_W + 1;

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic              pre;
        logic              act;
        logic              rd;
        logic              wrc;
        logic              rf;
        logic [ROW_W-1:0]  crow;
        logic [COL_W-1:0]  ccol;
        logic              rv;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t sq_d, sq_q;

    logic             ref_pending;
    logic [ROW_W-1:0] ref_row;
    acc_kind_e        kind;
    logic             trk_open;
    logic [ROW_W-1:0] trk_row;
    logic             go_act;
    logic             go_col;

    dps_refresh_ctl #(.T_REFI(T_REFI), .ROW_W(ROW_W)) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (sq_d.rf),
        .pending (ref_pending),
        .ref_row (ref_row)
    );

    dps_row_track #(.ROW_W(ROW_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_set  (sq_d.act),
        .close     (sq_d.pre),
        .set_row   (sq_d.crow),
        .probe_row (req_row),
        .kind      (kind),
        .is_open   (trk_open),
        .cur_row   (trk_row)
    );

    assign req_ready = (sq_q.st == S_IDLE) && !ref_pending;

    always_comb begin
        sq_d     = sq_q;
        sq_d.pre = 1'b0;
        sq_d.act = 1'b0;
        sq_d.rd  = 1'b0;
        sq_d.wrc = 1'b0;
        sq_d.rf  = 1'b0;
        sq_d.rv  = 1'b0;
        go_act   = 1'b0;
        go_col   = 1'b0;
        unique case (sq_q.st)
            S_IDLE: begin
                if (ref_pending) begin
                    if (trk_open) begin
                        sq_d.pre  = 1'b1;
                        sq_d.crow = trk_row;
                        sq_d.st   = S_RPRE;
                        sq_d.cnt  = CNT_W'(T_RP - 1);
                    end else begin
                        sq_d.rf   = 1'b1;
                        sq_d.crow = ref_row;
                        sq_d.st   = S_REF;
                        sq_d.cnt  = CNT_W'(T_RCD - 1);
                    end
                end else if (req_valid) begin
                    sq_d.wr    = req_write;
                    sq_d.row   = req_row;
                    sq_d.col   = req_col;
                    sq_d.wdata = req_wdata;
                    unique case (kind)
                        K_HIT:    go_col = 1'b1;
                        K_CLOSED: go_act = 1'b1;
                        default: begin
                            sq_d.pre  = 1'b1;
                            sq_d.crow = trk_row;
                            sq_d.st   = S_PRE;
                            sq_d.cnt  = CNT_W'(T_RP - 1);
                        end
                    endcase
                end
            end
            S_PRE: begin
                if (sq_q.cnt == '0) go_act = 1'b1;
                else sq_d.cnt = sq_q.cnt - 1'b1;
            end
            S_ACT: begin
                if (sq_q.cnt == '0) go_col = 1'b1;
                else sq_d.cnt = sq_q.cnt - 1'b1;
            end
            S_COL: begin
                if (sq_q.cnt == '0) begin
                    sq_d.rv  = !sq_q.wr;
                    if (!sq_q.wr) sq_d.rdata = dram_rdata;
                    sq_d.st  = S_REC;
                    sq_d.cnt = CNT_W'(T_REC - 1);
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            S_RPRE: begin
                if (sq_q.cnt == '0) begin
                    sq_d.rf   = 1'b1;
                    sq_d.crow = ref_row;
                    sq_d.st   = S_REF;
                    sq_d.cnt  = CNT_W'(T_RCD - 1);
                end else begin
                    sq_d.cnt = sq_q.cnt - 1'b1;
                end
            end
            default: begin
                if (sq_q.cnt == '0) sq_d.st = S_IDLE;
                else sq_d.cnt = sq_q.cnt - 1'b1;
            end
        endcase
        if (go_act) begin
            sq_d.act  = 1'b1;
            sq_d.crow = sq_d.row;
            sq_d.st   = S_ACT;
            sq_d.cnt  = CNT_W'(T_RCD - 1);
        end
        if (go_col) begin
            sq_d.rd   = !sq_d.wr;
            sq_d.wrc  = sq_d.wr;
            sq_d.crow = sq_d.row;
            sq_d.ccol = sq_d.col;
            sq_d.st   = S_COL;
            sq_d.cnt  = CNT_W'(T_CL - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q    <= '0;
            sq_q.st <= S_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign cmd_pre   = sq_q.pre;
    assign cmd_act   = sq_q.act;
    assign cmd_rd    = sq_q.rd;
    assign cmd_wr    = sq_q.wrc;
    assign cmd_ref   = sq_q.rf;
    assign cmd_row   = sq_q.crow;
    assign cmd_col   = sq_q.ccol;
    assign cmd_wdata = sq_q.wdata;
    assign rsp_valid = sq_q.rv;
    assign rsp_data  = sq_q.rdata;

    logic [GAP_W-1:0] since_pre_q, since_act_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_pre_q <= '1;
            since_act_q <= '1;
        end else begin
            since_pre_q <= (cmd_pre || cmd_ref) ? GAP_W'(1)
                         : (since_pre_q == '1) ? since_pre_q : since_pre_q + 1'b1;
            since_act_q <= cmd_act ? GAP_W'(1)
                         : (since_act_q == '1) ? since_act_q : since_act_q + 1'b1;
        end
    end

    p_one_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref}));
    p_col_on_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |-> trk_open);
    p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_act |-> (since_pre_q >= GAP_W'(T_RP)));
    p_col_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd || cmd_wr) |-> (since_act_q >= GAP_W'(T_RCD)));
    p_ref_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> !trk_open);
    p_busy_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);
endmodule

// File: tb/dram_page_seq_tb.sv
module dram_page_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
    localparam int T_RP = 3, T_RCD = 3, T_CL = 3, T_REC = 2, T_REFI = 120;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0, cmd_row;
    logic [COL_W-1:0] req_col = '0, cmd_col;
    logic [DATA_W-1:0] req_wdata = '0, cmd_wdata, dram_rdata, rsp_data;
    logic cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref, rsp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP),
        .T_RCD(T_RCD), .T_CL(T_CL), .T_REC(T_REC), .T_REFI(T_REFI)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .cmd_pre(cmd_pre), .cmd_act(cmd_act),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_ref(cmd_ref), .cmd_row(cmd_row),
        .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .dram_rdata(dram_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data));

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural bank: data path on posedge
    logic [DATA_W-1:0] mem [0:(1<<(ROW_W+COL_W))-1];
    logic [DATA_W-1:0] shadow [0:(1<<(ROW_W+COL_W))-1];
    logic [ROW_W-1:0] arr_row_p = '0;
    logic [DATA_W-1:0] arr_rdata = '0;
    assign dram_rdata = arr_rdata;
    initial for (int i = 0; i < (1<<(ROW_W+COL_W)); i++) begin
        mem[i] = DATA_W'(i * 7 + 3);
        shadow[i] = DATA_W'(i * 7 + 3);
    end
    always @(posedge clk) begin
        if (cmd_act) arr_row_p <= cmd_row;
        if (cmd_wr) mem[{arr_row_p, cmd_col}] <= cmd_wdata;
        if (cmd_rd) arr_rdata <= mem[{arr_row_p, cmd_col}];
    end

    // scoreboard and expected state
    int exp_data_q[$], exp_lat_q[$], exp_acc_q[$];
    bit exp_open = 0;
    int exp_row = 0, last_row = 0, last_col = 0;
    int prev_acc = -1000, prev_lat = 0;

    task automatic do_req(input bit wr, input int row, input int col, input int wd);
        int lat, acc, addr;
        req_valid = 1'b1; req_write = wr; req_row = ROW_W'(row);
        req_col = COL_W'(col); req_wdata = DATA_W'(wd);
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        if (!exp_open) lat = T_RCD + T_CL;
        else if (exp_row == row) lat = T_CL;
        else lat = T_RP + T_RCD + T_CL;
        exp_open = 1; exp_row = row; last_row = row; last_col = col;
        chk(acc - prev_acc >= prev_lat + T_REC + 1, "R7 accept spacing",
            acc - prev_acc, prev_lat + T_REC + 1);
        prev_acc = acc; prev_lat = lat;
        addr = row * (1 << COL_W) + col;
        if (wr) shadow[addr] = DATA_W'(wd);
        else begin
            exp_data_q.push_back(int'(shadow[addr]));
            exp_lat_q.push_back(lat);
            exp_acc_q.push_back(acc);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: command timing, refresh cadence, responses
    bit arr_open = 0;
    int arr_row = 0, since_pre = 1000, since_act = 1000, since_ref = 1000;
    int exp_ref_row = 0, last_ref = -1, ref_count = 0, idle_refs = 0;
    bit idle_phase = 0;
    always @(negedge clk) if (rst_n) begin
        since_pre++; since_act++; since_ref++;
        if (cmd_pre) begin
            arr_open = 0; since_pre = 0;
        end
        if (cmd_act) begin
            chk(!arr_open, "R6 activate on open bank", arr_open, 0);
            chk(since_pre >= T_RP, "R6 precharge-to-activate", since_pre, T_RP);
            chk(since_ref >= T_RCD, "R6 refresh-to-activate", since_ref, T_RCD);
            chk(int'(cmd_row) == last_row, "R2 activate row", cmd_row, last_row);
            arr_open = 1; arr_row = cmd_row; since_act = 0;
        end
        if (cmd_rd || cmd_wr) begin
            chk(arr_open, "R6 column on closed bank", arr_open, 1);
            chk(since_act >= T_RCD, "R6 activate-to-column", since_act, T_RCD);
            chk(int'(cmd_col) == last_col, "R2 column address", cmd_col, last_col);
            chk(arr_row == last_row, "R2 open row matches request", arr_row, last_row);
        end
        if (cmd_ref) begin
            chk(!arr_open, "R9 refresh with row open", arr_open, 0);
            chk(int'(cmd_row) == exp_ref_row, "R9 refresh row order", cmd_row, exp_ref_row);
            if (idle_phase) begin
                if (idle_refs >= 2)
                    chk(cyc - last_ref == T_REFI, "R8 idle refresh interval",
                        cyc - last_ref, T_REFI);
                idle_refs++;
            end
            exp_ref_row = (exp_ref_row + 1) % (1 << ROW_W);
            exp_open = 0; since_ref = 0; last_ref = cyc; ref_count++;
        end
        if (rsp_valid) begin
            if (exp_data_q.size() == 0) begin
                chk(0, "R12 unexpected response (R11 write must not respond)", 1, 0);
            end else begin
                int ed, el, ea;
                ed = exp_data_q.pop_front(); el = exp_lat_q.pop_front();
                ea = exp_acc_q.pop_front();
                chk(int'(rsp_data) == ed, "R12/R11 read data in order", rsp_data, ed);
                chk(cyc - ea == el, "R3/R4/R5 read latency", cyc - ea, el);
            end
        end
    end

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", cyc, 20000);
        finish_run();
    end

    task automatic drain();
        int n;
        n = 0;
        while (exp_data_q.size() != 0 && n < 200) begin
            @(negedge clk); n++;
        end
        chk(exp_data_q.size() == 0, "R12 all responses returned", exp_data_q.size(), 0);
    endtask

    initial begin
        int refs_before;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        chk({cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref, rsp_valid} == 6'b0,
            "R1 no pulses after reset", {cmd_pre, cmd_act, cmd_rd, cmd_wr, cmd_ref}, 0);
        // R3 closed, R4 hit, R5 conflict
        do_req(0, 3, 1, 0);
        do_req(0, 3, 2, 0);
        do_req(0, 5, 0, 0);
        // R11 write then read back, in same and different rows
        do_req(1, 5, 7, 8'hAA);
        do_req(0, 5, 7, 0);
        do_req(1, 2, 4, 8'h55);
        do_req(0, 2, 4, 0);
        drain();
        // R8 idle refresh cadence
        idle_phase = 1;
        repeat (4 * T_REFI + 10) @(negedge clk);
        idle_phase = 0;
        chk(idle_refs >= 4, "R8 refreshes while idle", idle_refs, 4);
        // R9: after refresh the old row is closed (expect closed latency)
        do_req(0, 2, 4, 0);
        drain();
        // R10/R12/R7: back-to-back stream with writes mixed in
        refs_before = ref_count;
        for (int i = 0; i < 48; i++) begin
            do_req((i % 4) == 3, (i / 3) % 5, (i * 5) % 16, i * 11 + 1);
        end
        drain();
        chk(ref_count - refs_before >= 2, "R10 refresh not starved by stream",
            ref_count - refs_before, 2);
        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule